// File: doc/BRIEF.md
# Glitch-Free Reference Clock Switch

This block picks one of two unrelated clocks, an on-chip reference and an off-chip reference, and passes it to a single output. A level on a select input decides which one is used. The selection can change at any time, and the output never shows a shortened high pulse or a shortened low gap. Each source reaches the output through its own AND gate. The two gate enables are never open together, and each enable only moves while its own clock is low.

The two directions of a switch use different detection. Leaving the internal clock is edge-driven: the select is synchronised on falling edges of the internal clock, and that gate closes on one of those edges. A registered hand-off is then passed into the external domain, and the external gate opens on a falling external edge. Leaving the external clock is level-driven: the external gate is cleared at once whenever the synchronised select asks for the internal clock and the external clock is low. This lets the switch finish even when the external clock has stopped low. The internal gate then reopens on a falling internal edge, once the internal domain has seen that every external stage is idle.

Top module: `refclk_switch`

## Requirements
- R1: With `sel_int` high and held, `clk_out` settles to a copy of `int_clk` with the same period.
- R2: With `sel_int` low and held and `ext_clk` running, `clk_out` settles to a copy of `ext_clk` with the same period.
- R3: Every high pulse on `clk_out` is a complete high phase of the source that produced it. None is narrower than the narrower of the two sources' high phases.
- R4: When moving away from the internal clock, `clk_out` stays low for at least half an internal period after the internal gate closes. Every low interval on `clk_out` is at least half an internal period long.
- R5: A move from the external clock back to the internal clock completes when `ext_clk` has stopped at a low level.
- R6: If `ext_clk` is stuck high while the external path is selected, raising `sel_int` never hands over to the internal clock, and `clk_out` stays high.
- R7: The internal and external gate enables are never open at the same time.
- R8: While `rst_n` is low, `clk_out` is low and both gates are closed.
- R9: The internal enable changes only while `int_clk` is low. The external enable changes only while `ext_clk` is low. The external enable opens only after the hand-off from the internal domain has passed its synchroniser.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| int_clk | input | 1 | Internal reference clock |
| ext_clk | input | 1 | External reference clock, unrelated to `int_clk` |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_int | input | 1 | Asynchronous select: 1 picks the internal clock, 0 the external clock |
| clk_out | output | 1 | Gated output clock |

## Verification
The properties assume that `sel_int` is a clean level and that both clocks are free of glitches. The external clock may stop or stick at either level, but only at the end of a whole phase. The stimulus meets these assumptions. `sel_int` only changes at chosen offsets from an internal rising edge, and the external generator only freezes after it has finished its current half period. The bench sweeps several external half periods against several select phases and times every pulse and every gap on `clk_out`. It then drives the stopped-low case and the stuck-high case.

// File: rtl/refclk_switch.sv
module refclk_switch (
  input  logic int_clk,
  input  logic ext_clk,
  input  logic rst_n,
  input  logic sel_int,
  output logic clk_out
);

  logic sel_m, sel_s;
  logic hd1, hd2;
  logic busy_m, busy_s;
  logic int_en, hand_ext;
  logic ext_m, ext_q, ext_en;
  logic ext_clr, ext_busy;

  always_ff @(negedge int_clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_m  <= 1'b0;
      sel_s  <= 1'b0;
      hd1    <= 1'b0;
      hd2    <= 1'b0;
      busy_m <= 1'b0;
      busy_s <= 1'b0;
      int_en <= 1'b0;
    end else begin
      sel_m  <= sel_int;
      sel_s  <= sel_m;
      hd1    <= sel_s & ~hand_ext;
      hd2    <= hd1;
      busy_m <= ext_busy;
      busy_s <= busy_m;
      int_en <= sel_s & hd2 & ~busy_s & ~hand_ext;
    end
  end

  always_ff @(posedge int_clk or negedge rst_n) begin
    if (!rst_n) hand_ext <= 1'b0;
    else        hand_ext <= ~sel_s & ~int_en;
  end

  assign ext_clr = ~rst_n | (sel_s & ~ext_clk);

  always_ff @(negedge ext_clk or posedge ext_clr) begin
    if (ext_clr) begin
      ext_m  <= 1'b0;
      ext_q  <= 1'b0;
      ext_en <= 1'b0;
    end else begin
      ext_m  <= hand_ext;
      ext_q  <= ext_m;
      ext_en <= ext_q;
    end
  end

  assign ext_busy = ext_m | ext_q | ext_en;
  assign clk_out  = (int_clk & int_en) | (ext_clk & ext_en);

endmodule

// File: rtl/refclk_switch_chk.sv
module refclk_switch_chk (
  input logic int_clk,
  input logic ext_clk,
  input logic rst_n,
  input logic clk_out,
  input logic int_en,
  input logic ext_en,
  input logic hand_ext,
  input logic ext_q
);

  a_r7_excl_int: assert property (@(posedge int_clk) disable iff (!rst_n)
    !(int_en && ext_en));

  a_r7_excl_ext: assert property (@(posedge ext_clk) disable iff (!rst_n)
    !(int_en && ext_en));

  a_r7_int_needs_no_handoff: assert property (@(posedge int_clk) disable iff (!rst_n)
    int_en |-> !hand_ext);

  a_r9_ext_after_sync: assert property (@(posedge ext_clk) disable iff (!rst_n)
    $rose(ext_en) |-> $past(ext_q));

  always @(int_en) begin
    if (rst_n) a_r9_int_low_change: assert (!int_clk);
  end

  always @(ext_en) begin
    if (rst_n) a_r9_ext_low_change: assert (!ext_clk);
  end

  always @(negedge int_clk) begin
    if (!rst_n) a_r8_quiet_in_reset: assert (!clk_out && !int_en && !ext_en);
  end

endmodule

bind refclk_switch refclk_switch_chk u_chk (
  .int_clk (int_clk),
  .ext_clk (ext_clk),
  .rst_n   (rst_n),
  .clk_out (clk_out),
  .int_en  (int_en),
  .ext_en  (ext_en),
  .hand_ext(hand_ext),
  .ext_q   (ext_q)
);

// File: tb/refclk_switch_bench.sv
`timescale 1ns/1ps
module refclk_switch_bench;

  logic int_clk = 1'b0;
  logic ext_clk = 1'b0;
  logic rst_n   = 1'b1;
  logic sel_int = 1'b1;
  logic clk_out;

  int n_chk  = 0;
  int n_fail = 0;
  int ext_mode = 0;
  realtime ext_half = 3.5;
  realtime last_r = 0.0;
  realtime last_f = 0.0;
  bit mon_on = 1'b0;
  bit done = 1'b0;

  refclk_switch u_refclk_switch (
    .int_clk(int_clk), .ext_clk(ext_clk), .rst_n(rst_n),
    .sel_int(sel_int), .clk_out(clk_out)
  );

  always #2.5 int_clk = ~int_clk;

  initial begin
    forever begin
      if (ext_mode == 1 && !ext_clk)     #1;
      else if (ext_mode == 2 && ext_clk) #1;
      else begin
        #(ext_half);
        ext_clk = ~ext_clk;
      end
    end
  end

  function automatic realtime min_high();
    return (ext_half < 2.5) ? ext_half : 2.5;
  endfunction

  task automatic check(input bit ok, input string tag, input real act, input real exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %f expected %f at %0t", tag, act, exp, $time);
    end
  endtask

  // R3 / R7 / R9: a gate opening early or overlapping would cut or merge phases
  always @(negedge clk_out) begin
    if (mon_on && last_r > 0.0)
      check(($realtime - last_r) >= min_high() - 0.01, "R3 high width",
            $realtime - last_r, min_high());
    last_f = $realtime;
  end

  // R4: every low gap at least half an internal period
  always @(posedge clk_out) begin
    if (mon_on && last_f > 0.0)
      check(($realtime - last_f) >= 2.49, "R4 low gap", $realtime - last_f, 2.5);
    last_r = $realtime;
  end

  task automatic measure(input string tag, input realtime exp);
    realtime t0;
    @(posedge clk_out); t0 = $realtime;
    @(posedge clk_out);
    check((($realtime - t0) - exp) < 0.01 && (exp - ($realtime - t0)) < 0.01,
          tag, $realtime - t0, exp);
  endtask

  task automatic set_sel(input bit v, input realtime off);
    @(posedge int_clk);
    #(off);
    sel_int = v;
  endtask

  initial begin
    #1 rst_n = 1'b0;
    #20;
    check(clk_out == 1'b0, "R8 reset low", clk_out, 0);
    #7.3;
    check(clk_out == 1'b0, "R8 reset low", clk_out, 0);
    rst_n = 1'b1;
    #100;
    mon_on = 1'b1;
    measure("R1 internal period", 5.0);

    for (int h = 0; h < 4; h++) begin
      realtime halves[4] = '{3.5, 6.5, 11.5, 18.5};
      for (int o = 0; o < 4; o++) begin
        realtime offs[4] = '{0.3, 1.4, 2.6, 4.1};
        ext_half = halves[h];
        #60;
        set_sel(1'b0, offs[o]);
        #400;
        measure("R2 external period", 2.0 * ext_half);
        set_sel(1'b1, offs[(o + 1) % 4]);
        #200;
        measure("R1 internal period", 5.0);
      end
    end

    // R5: external clock stopped low, return to internal still completes
    ext_half = 6.5;
    #60;
    set_sel(1'b0, 1.1);
    #400;
    measure("R2 external period", 13.0);
    ext_mode = 1;
    #40;
    set_sel(1'b1, 3.3);
    #150;
    measure("R5 stopped-low return", 5.0);
    ext_mode = 0;
    #100;

    // R6: external clock stuck high blocks the return
    set_sel(1'b0, 0.7);
    #400;
    measure("R2 external period", 13.0);
    ext_mode = 2;
    #30;
    set_sel(1'b1, 2.2);
    for (int k = 0; k < 6; k++) begin
      #47.3;
      check(clk_out == 1'b1, "R6 stuck high holds", clk_out, 1);
    end
    ext_mode = 0;
    #200;
    measure("R6 release then internal", 5.0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule